// File: doc/BRIEF.md
# Special-Purpose Register Bank with Interrupt Capture

This block is the bank of special 16-bit registers that a small 16-bit processor keeps beside its general register file. Software reaches it through one read port and one write port. Both use a 6-bit index, which the datapath takes from bits 5:0 of the instruction word. A read is combinational. A write takes effect at the next rising clock edge when the write enable is high.

Entries 0 to 3 are ordinary registers, and each one also drives its own display output pin. Entry 5 returns the live value on the switch inputs. Entry 6 returns the live program counter. Entry 7 keeps the return address saved when an exception or interrupt is taken. Entry 8 keeps a flag word that describes the last interrupt. Entries 10 to 32 are plain storage that keeps its contents across function calls. Entries 4 and 9 are reserved, and so is every index from 33 to 63.

When the sequencer takes an interrupt, it pulses a capture input. In that one cycle the bank loads the saved PC into entry 7 and a packed flag word into entry 8, using paths of their own.

Top module: `spr_bank`

## Requirements
- R1: While reset is held, and after it is released, every writable entry (0-3, 7, 8 and 10-32) reads zero and all four display outputs are zero.
- R2: A write to index 0, 1, 2 or 3 changes the display output with the same number to the written data from the next cycle, and that entry reads back the same value.
- R3: A read of index 5 returns the current value of the switch input, changing with it in the same cycle. A write to index 5 has no effect.
- R4: A read of index 6 returns the current value of the program counter input. A write to index 6 has no effect.
- R5: Indices 4, 9 and 33 to 63 always read zero. A write to any of them changes no other entry and no display output.
- R6: When the capture input is high at a clock edge, entry 7 then holds the captured PC. Entry 8 then holds the flag word, which has the 3-bit type in bits 15:13, zeros in bits 12:6 and the 6-bit code in bits 5:0.
- R7: If a software write to index 7 or 8 falls in the same cycle as a capture, the capture value is stored and the software data is discarded.
- R8: A software write to any other writable index in a capture cycle still takes effect.
- R9: Indices 10 to 32 store written data. Every stored entry keeps its value in a cycle with neither a write nor a capture.
- R10: With no capture pending, software can write indices 7 and 8 like storage, with all 16 bits kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx | input | 6 | Read index |
| rd_data | output | 16 | Read data, combinational |
| wr_en | input | 1 | Software write enable |
| wr_idx | input | 6 | Write index |
| wr_data | input | 16 | Write data |
| sw_in | input | 16 | Live switch inputs |
| pc_in | input | 16 | Live program counter |
| irq_take | input | 1 | Interrupt capture strobe |
| irq_pc | input | 16 | PC value to save on capture |
| irq_type | input | 3 | Interrupt type for the flag word |
| irq_code | input | 6 | Interrupt code for the flag word |
| disp0 | output | 16 | Display 0 value |
| disp1 | output | 16 | Display 1 value |
| disp2 | output | 16 | Display 2 value |
| disp3 | output | 16 | Display 3 value |

## Verification
The assertions check on every cycle that a capture lands in entries 7 and 8 ahead of any software write. They also check that the flag word has zero reserved bits, that a display write appears on its pin one cycle later, and that a write to a reserved index leaves every display unchanged. Finally, they check that stored state holds steady in cycles with no write and no capture. The values seen after reset, the live switch and PC views, the zero returned by reserved and out-of-range indices, and a software write to another entry in the same cycle as a capture are all shown only by the bench's scenarios.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int DATA_W    = 16;
    localparam int IDX_W     = 6;
    localparam int NUM_ENT   = 33;
    localparam int NUM_DISP  = 4;
    localparam int TYPE_W    = 3;
    localparam int CODE_W    = 6;
    localparam int RSVD_W    = DATA_W - TYPE_W - CODE_W;

    localparam int IDX_RSV_A  = 4;
    localparam int IDX_SWITCH = 5;
    localparam int IDX_PCVIEW = 6;
    localparam int IDX_EPC    = 7;
    localparam int IDX_FLAG   = 8;
    localparam int IDX_RSV_B  = 9;
    localparam int IDX_KEEP0  = 10;

    typedef enum logic [2:0] {
        K_DISP,
        K_SWITCH,
        K_PCVIEW,
        K_EPC,
        K_FLAG,
        K_KEEP,
        K_RSVD
    } ent_kind_e;

    typedef struct packed {
        logic [TYPE_W-1:0] kind;
        logic [RSVD_W-1:0] rsvd;
        logic [CODE_W-1:0] code;
    } irq_flag_t;

    function automatic ent_kind_e kind_of(input int idx);
        if (idx < NUM_DISP)            return K_DISP;
        else if (idx == IDX_SWITCH)    return K_SWITCH;
        else if (idx == IDX_PCVIEW)    return K_PCVIEW;
        else if (idx == IDX_EPC)       return K_EPC;
        else if (idx == IDX_FLAG)      return K_FLAG;
        else if (idx >= IDX_KEEP0 && idx < NUM_ENT) return K_KEEP;
        else                           return K_RSVD;
    endfunction

    function automatic logic is_stored(input ent_kind_e k);
        return (k == K_DISP) || (k == K_EPC) || (k == K_FLAG) || (k == K_KEEP);
    endfunction

    function automatic irq_flag_t pack_flag(input logic [TYPE_W-1:0] t,
                                            input logic [CODE_W-1:0] c);
        irq_flag_t f;
        f.kind = t;
        f.rsvd = '0;
        f.code = c;
        return f;
    endfunction

endpackage

// File: rtl/spr_wr_decode.sv
module spr_wr_decode
    import spr_pkg::*;
#(
    parameter int P_IDX_W   = IDX_W,
    parameter int P_NUM_ENT = NUM_ENT
) (
    input  logic               wr_en,
    input  logic [P_IDX_W-1:0] wr_idx,
    output logic [P_NUM_ENT-1:0] we_vec
);
    for (genvar i = 0; i < P_NUM_ENT; i++) begin : g_dec
        localparam ent_kind_e K = kind_of(i);
        if (is_stored(K)) begin : g_wr
            assign we_vec[i] = wr_en && (wr_idx == P_IDX_W'(i));
        end else begin : g_ro
            assign we_vec[i] = 1'b0;
        end
    end
endmodule

// File: rtl/spr_store.sv
module spr_store
    import spr_pkg::*;
#(
    parameter int P_NUM_ENT = NUM_ENT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [P_NUM_ENT-1:0]  we_vec,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  irq_take,
    input  logic [DATA_W-1:0]     irq_pc,
    input  irq_flag_t             irq_flag,
    output logic [P_NUM_ENT-1:0][DATA_W-1:0] q_arr
);
    for (genvar i = 0; i < P_NUM_ENT; i++) begin : g_ent
        localparam ent_kind_e K = kind_of(i);
        if (K == K_EPC || K == K_FLAG) begin : g_cap
            logic [DATA_W-1:0] cap_val;
            assign cap_val = (K == K_EPC) ? irq_pc : DATA_W'(irq_flag);
            always_ff @(posedge clk) begin
                if (rst)           q_arr[i] <= '0;
                else if (irq_take) q_arr[i] <= cap_val;
                else if (we_vec[i]) q_arr[i] <= wr_data;
            end
        end else if (is_stored(K)) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)            q_arr[i] <= '0;
                else if (we_vec[i]) q_arr[i] <= wr_data;
            end
        end else begin : g_none
            assign q_arr[i] = '0;
        end
    end

    // R6 R7
    epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> q_arr[IDX_EPC] == $past(irq_pc));

    // R6
    flag_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> q_arr[IDX_FLAG][DATA_W-TYPE_W-1:CODE_W] == '0);

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (we_vec == '0 && !irq_take) |=> $stable(q_arr));
endmodule

// File: rtl/spr_rd_mux.sv
module spr_rd_mux
    import spr_pkg::*;
#(
    parameter int P_IDX_W   = IDX_W,
    parameter int P_NUM_ENT = NUM_ENT
) (
    input  logic [P_IDX_W-1:0]               rd_idx,
    input  logic [P_NUM_ENT-1:0][DATA_W-1:0] q_arr,
    input  logic [DATA_W-1:0]                sw_in,
    input  logic [DATA_W-1:0]                pc_in,
    output logic [DATA_W-1:0]                rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < P_NUM_ENT; i++) begin
            if (rd_idx == P_IDX_W'(i)) begin
                unique case (kind_of(i))
                    K_SWITCH: rd_data = sw_in;
                    K_PCVIEW: rd_data = pc_in;
                    K_RSVD:   rd_data = '0;
                    default:  rd_data = q_arr[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/spr_bank.sv
module spr_bank
    import spr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] sw_in,
    input  logic [DATA_W-1:0] pc_in,
    input  logic              irq_take,
    input  logic [DATA_W-1:0] irq_pc,
    input  logic [TYPE_W-1:0] irq_type,
    input  logic [CODE_W-1:0] irq_code,
    output logic [DATA_W-1:0] disp0,
    output logic [DATA_W-1:0] disp1,
    output logic [DATA_W-1:0] disp2,
    output logic [DATA_W-1:0] disp3
);
    logic [NUM_ENT-1:0]             we_vec;
    logic [NUM_ENT-1:0][DATA_W-1:0] q_arr;
    irq_flag_t                      flag_word;

    assign flag_word = pack_flag(irq_type, irq_code);

    spr_wr_decode #(.P_IDX_W(IDX_W), .P_NUM_ENT(NUM_ENT)) u_dec (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .we_vec (we_vec)
    );

    spr_store #(.P_NUM_ENT(NUM_ENT)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we_vec   (we_vec),
        .wr_data  (wr_data),
        .irq_take (irq_take),
        .irq_pc   (irq_pc),
        .irq_flag (flag_word),
        .q_arr    (q_arr)
    );

    spr_rd_mux #(.P_IDX_W(IDX_W), .P_NUM_ENT(NUM_ENT)) u_rd (
        .rd_idx  (rd_idx),
        .q_arr   (q_arr),
        .sw_in   (sw_in),
        .pc_in   (pc_in),
        .rd_data (rd_data)
    );

    assign disp0 = q_arr[0];
    assign disp1 = q_arr[1];
    assign disp2 = q_arr[2];
    assign disp3 = q_arr[3];

    // R2
    disp0_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_W'(0)) |=> disp0 == $past(wr_data));

    // R2
    disp3_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_W'(3)) |=> disp3 == $past(wr_data));

    // R5
    rsvd_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx == IDX_W'(IDX_RSV_A) || wr_idx == IDX_W'(IDX_RSV_B)))
        |=> ($stable(disp0) && $stable(disp1) && $stable(disp2) && $stable(disp3)));

    // R7
    flag_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_take && wr_en && wr_idx == IDX_W'(IDX_FLAG))
        |=> q_arr[IDX_FLAG][CODE_W-1:0] == $past(irq_code));
endmodule

// File: tb/test_spr_bank.sv
`timescale 1ns/1ps
module test_spr_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] sw_in = 16'hA5A5;
    logic [15:0] pc_in = 16'h0100;
    logic        irq_take = 1'b0;
    logic [15:0] irq_pc = '0;
    logic [2:0]  irq_type = '0;
    logic [5:0]  irq_code = '0;
    logic [15:0] disp0, disp1, disp2, disp3;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    spr_bank i_spr_bank (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sw_in(sw_in), .pc_in(pc_in), .irq_take(irq_take),
        .irq_pc(irq_pc), .irq_type(irq_type), .irq_code(irq_code),
        .disp0(disp0), .disp1(disp1), .disp2(disp2), .disp3(disp3)
    );

    // monitor: compares one expected item per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            logic [15:0] got;
            it = exp_q.pop_front();
            case (it.sel)
                1: got = disp0;
                2: got = disp1;
                3: got = disp2;
                4: got = disp3;
                default: got = rd_data;
            endcase
            tests++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic we, input logic [5:0] wi, input logic [15:0] wd,
                         input logic it, input logic [15:0] ip,
                         input logic [2:0] ty, input logic [5:0] cd);
        wr_en = we; wr_idx = wi; wr_data = wd;
        irq_take = it; irq_pc = ip; irq_type = ty; irq_code = cd;
        tick();
        wr_en = 1'b0; irq_take = 1'b0;
    endtask

    task automatic wr(input logic [5:0] wi, input logic [15:0] wd);
        drive(1'b1, wi, wd, 1'b0, 16'h0, 3'd0, 6'd0);
    endtask

    // sel 0 = rd_data at idx, 1..4 = display outputs
    task automatic expect_val(input int sel, input logic [5:0] idx,
                              input logic [15:0] e, input string req);
        item_t it;
        rd_idx = idx;
        it.sel = sel; it.exp = e; it.req = req;
        exp_q.push_back(it);
        tick();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1 while reset held
        expect_val(1, 6'd0, 16'h0000, "R1 disp0 in reset");
        rst = 1'b0;
        // R1 after release
        expect_val(0, 6'd0, 16'h0000, "R1 idx0");
        expect_val(0, 6'd7, 16'h0000, "R1 idx7");
        expect_val(0, 6'd8, 16'h0000, "R1 idx8");
        expect_val(0, 6'd20, 16'h0000, "R1 idx20");
        expect_val(4, 6'd0, 16'h0000, "R1 disp3");

        // R2 display writes
        wr(6'd0, 16'h1111); wr(6'd1, 16'h2222); wr(6'd2, 16'h3333); wr(6'd3, 16'h4444);
        expect_val(1, 6'd0, 16'h1111, "R2 disp0");
        expect_val(2, 6'd0, 16'h2222, "R2 disp1");
        expect_val(3, 6'd0, 16'h3333, "R2 disp2");
        expect_val(4, 6'd0, 16'h4444, "R2 disp3");
        expect_val(0, 6'd2, 16'h3333, "R2 readback idx2");

        // R3 switch view
        expect_val(0, 6'd5, 16'hA5A5, "R3 switch read");
        wr(6'd5, 16'h1234);
        expect_val(0, 6'd5, 16'hA5A5, "R3 write ignored");
        sw_in = 16'h0F0F;
        expect_val(0, 6'd5, 16'h0F0F, "R3 live update");

        // R4 pc view
        expect_val(0, 6'd6, 16'h0100, "R4 pc read");
        wr(6'd6, 16'hDEAD);
        pc_in = 16'h0204;
        expect_val(0, 6'd6, 16'h0204, "R4 write ignored, live");

        // R5 reserved indices
        wr(6'd4, 16'hFFFF);
        expect_val(0, 6'd4, 16'h0000, "R5 idx4 reads zero");
        expect_val(4, 6'd0, 16'h4444, "R5 disp3 untouched");
        expect_val(0, 6'd3, 16'h4444, "R5 idx3 untouched");
        wr(6'd9, 16'hFFFF);
        expect_val(0, 6'd9, 16'h0000, "R5 idx9 reads zero");
        expect_val(0, 6'd8, 16'h0000, "R5 idx8 untouched");
        wr(6'd40, 16'hFFFF);
        expect_val(0, 6'd40, 16'h0000, "R5 idx40 reads zero");
        wr(6'd63, 16'hFFFF);
        expect_val(0, 6'd63, 16'h0000, "R5 idx63 reads zero");
        expect_val(0, 6'd0, 16'h1111, "R5 idx0 untouched");

        // R10 software access to 7 and 8
        wr(6'd7, 16'h4545);
        wr(6'd8, 16'hFFFF);
        expect_val(0, 6'd7, 16'h4545, "R10 idx7 sw write");
        expect_val(0, 6'd8, 16'hFFFF, "R10 idx8 all bits");

        // R6 capture: flag = type<<13 | code
        drive(1'b0, 6'd0, 16'h0, 1'b1, 16'h1357, 3'd5, 6'h2A);
        expect_val(0, 6'd7, 16'h1357, "R6 epc capture");
        expect_val(0, 6'd8, 16'hA02A, "R6 flag format");

        // R7 capture beats software write
        drive(1'b1, 6'd7, 16'hBEEF, 1'b1, 16'h2468, 3'd2, 6'h01);
        expect_val(0, 6'd7, 16'h2468, "R7 epc priority");
        expect_val(0, 6'd8, 16'h4001, "R7 flag from capture");
        drive(1'b1, 6'd8, 16'hFFFF, 1'b1, 16'h0ACE, 3'd7, 6'h3F);
        expect_val(0, 6'd8, 16'hE03F, "R7 flag priority");

        // R8 other write in capture cycle
        drive(1'b1, 6'd12, 16'h5A5A, 1'b1, 16'h0002, 3'd1, 6'h05);
        expect_val(0, 6'd12, 16'h5A5A, "R8 concurrent write");
        expect_val(0, 6'd7, 16'h0002, "R8 capture also done");
        drive(1'b1, 6'd1, 16'h7777, 1'b1, 16'h0003, 3'd1, 6'h06);
        expect_val(2, 6'd0, 16'h7777, "R8 concurrent disp1 write");

        // R9 storage
        wr(6'd10, 16'hC0DE); wr(6'd32, 16'hF00D); wr(6'd21, 16'h0BAD);
        repeat (4) tick();
        expect_val(0, 6'd10, 16'hC0DE, "R9 idx10");
        expect_val(0, 6'd32, 16'hF00D, "R9 idx32");
        expect_val(0, 6'd21, 16'h0BAD, "R9 idx21");
        expect_val(0, 6'd11, 16'h0000, "R9 idx11 untouched");

        repeat (2) tick();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule